// File: doc/BRIEF.md
# Receive Frame Slip Buffer for T1/E1 PCM

This block is a two-frame elastic store that sits between the line-side receive bit stream and the system-bus bit stream of a T1 or E1 receiver. One clock drives both sides. The line side writes one PCM bit each cycle that its write strobe is high, and the bus side reads one bit each cycle that its read strobe is high. The bus side keeps its own frame counter and marks the first bit of each bus frame with a sync pulse.

The buffer holds two frames. The reader checks how far it trails the writer, and it acts only when it reaches the first bit of a bus frame. If the reader has come too close to the writer, it replays the previous frame. If it has fallen too far behind, it skips one frame. In both cases the bus frame sync stays where it was. These are controlled slips. A change of configuration is handled as an uncontrolled slip: the buffer realigns its pointers and restarts the frame counter. In short-delay mode, a reader that runs dry is also handled as an uncontrolled slip.

The slip status bits latch active high, together with a direction bit and a combined slip flag. They clear either when software reads them or after a fixed hold time. A coarse flag shows whether the current read-to-write distance exceeds one frame. A bypass mode feeds the reader the most recently written bit and reports no controlled slips.

Top module: `rx_slip_buffer`

## Requirements
- R1: Written bits are stored at the write pointer and read back in the same order. `rd_bit` changes only in the cycle after a read strobe. The buffer holds 2×193 bits (T1, `e1_sel`=0) or 2×256 bits (E1, `e1_sel`=1), and both pointers wrap at that depth.
- R2: `rd_fsync` is high for exactly one cycle. That cycle follows a read strobe that read bus frame position 0. The bus frame is 193 bits long (T1) or 256 bits (E1). A controlled slip leaves the bus frame position unchanged.
- R3: A read at bus frame position 0 can repeat a frame. This happens in normal mode (`mode_sel` 00 or 11) and in short mode after it has reverted. If the write-minus-read distance (modulo depth) is below GUARD (16), the read address moves back one frame. `slip_ctrl` is then set and `slip_dir` is set to 1.
- R4: Under the same conditions, if the distance is greater than depth − GUARD, the read address moves forward one frame. `slip_ctrl` is then set and `slip_dir` is cleared to 0.
- R5: `dly_gt_frame` is 1 exactly when the current write-minus-read distance is greater than 192 (T1) or greater than 256 (E1).
- R6: A change of `mode_sel` or `e1_sel` realigns the buffer in the cycle it is seen. The write pointer goes to 0, the read pointer goes to one frame length, and the frame counter goes to 0. `slip_unctrl` is set and `slip_dir` is cleared to 0. A read or write strobe in that cycle is not carried out.
- R7: In short mode (`mode_sel`=01), before any revert, a read that finds a distance of 0 reads from one frame ahead of the write pointer. That read is taken as frame position 0 (so `rd_fsync` follows), `slip_unctrl` is set and `slip_dir` is cleared to 0.
- R8: In short mode, a read at frame position 0 with a distance above depth − GUARD deletes a frame as in R4. The block then behaves as in normal mode until the next configuration change.
- R9: In bypass mode (`mode_sel`=10), a read returns the bit written last (write pointer − 1). No slip is taken, and `slip_ctrl` reads 0.
- R10: `slip_any` is the OR of the visible `slip_ctrl` and `slip_unctrl`.
- R11: With `hold_sel`=0, a `status_rd` pulse clears `slip_ctrl` and `slip_unctrl` in the next cycle. A slip event in the same cycle still leaves its own bit set. `slip_dir` changes only on events.
- R12: With `hold_sel`=1, the slip bits stay set for HOLD_CYC (64) cycles after the last event and then clear. `status_rd` has no effect in this mode.
- R13: After reset the status bits, `rd_bit` and `rd_fsync` are 0. The block starts in normal T1 operation with a distance of 193, so `dly_gt_frame` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both sides |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | 00 normal, 01 short delay, 10 bypass, 11 normal |
| e1_sel | input | 1 | 0 T1 framing, 1 E1 framing |
| hold_sel | input | 1 | 0 clear status on read, 1 fixed hold time |
| wr_en | input | 1 | Line-side bit strobe |
| wr_bit | input | 1 | Line-side PCM bit |
| rd_en | input | 1 | Bus-side bit strobe |
| rd_bit | output | 1 | Bus-side PCM bit |
| rd_fsync | output | 1 | Bus frame start marker |
| status_rd | input | 1 | Status read strobe |
| slip_ctrl | output | 1 | Controlled slip latched |
| slip_unctrl | output | 1 | Uncontrolled slip latched |
| slip_dir | output | 1 | Last slip: 1 repeat, 0 delete or realign |
| slip_any | output | 1 | Either slip latched |
| dly_gt_frame | output | 1 | Distance exceeds one frame |

## Verification
The assertions assume that the strobes keep the two sides close enough in rate. Over one frame the distance should drift by less than GUARD, so that a slip at a frame boundary restores the margin before the pointers can cross. They also assume that the configuration inputs change only between strobes that matter, because a change is itself an event. The stimulus makes the strobes with fractional-rate accumulators whose rates differ by 3 percent. That gives a drift of about 12 bits per frame, with no random bunching. The stimulus changes configuration only at phase boundaries.

// File: rtl/rxsb_pkg.sv
package rxsb_pkg;
    typedef enum logic [1:0] {
        SB_NORMAL = 2'b00,
        SB_SHORT  = 2'b01,
        SB_BYPASS = 2'b10,
        SB_SPARE  = 2'b11
    } sb_mode_e;

    typedef struct packed {
        logic ctrl;
        logic unctrl;
        logic dir;
    } sb_event_t;
endpackage

// File: rtl/rxsb_store.sv
module rxsb_store #(
    parameter int DEPTH_MAX = 512,
    localparam int AW = $clog2(DEPTH_MAX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_bit,
    input  logic          realign,
    input  logic [AW:0]   depth,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_data,
    output logic [AW-1:0] wptr
);
    typedef struct packed {
        logic [DEPTH_MAX-1:0] mem;
        logic [AW-1:0]        wptr;
    } store_t;

    store_t st_d, st_q;
    logic [AW:0] wnext;

    always_comb begin
        st_d  = st_q;
        wnext = {1'b0, st_q.wptr} + 1'b1;
        if (realign) begin
            st_d.wptr = '0;
        end else if (wr_en) begin
            st_d.mem[st_q.wptr] = wr_bit;
            st_d.wptr = (wnext >= depth) ? '0 : wnext[AW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.mem[rd_addr];
    assign wptr    = st_q.wptr;

    assert_wptr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !realign && (({1'b0, st_q.wptr} + 1'b1) < depth))
        |=> (st_q.wptr == AW'($past(st_q.wptr) + 1'b1)));
endmodule

// File: rtl/rxsb_reader.sv
module rxsb_reader import rxsb_pkg::*; #(
    parameter int T1_LEN    = 193,
    parameter int E1_LEN    = 256,
    parameter int T1_DLY_TH = 192,
    parameter int GUARD     = 16,
    parameter int AW        = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic          e1_sel,
    input  logic          rd_en,
    input  logic [AW-1:0] wptr,
    input  logic          rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          realign,
    output logic [AW:0]   depth,
    output logic          rd_bit,
    output logic          rd_fsync,
    output logic          dly,
    output logic          bypass,
    output sb_event_t     ev
);
    localparam int CW = AW + 2;
    localparam logic [CW-1:0] T1_L  = CW'(T1_LEN);
    localparam logic [CW-1:0] E1_L  = CW'(E1_LEN);
    localparam logic [CW-1:0] GRD   = CW'(GUARD);
    localparam logic [CW-1:0] ONE   = CW'(1);

    typedef struct packed {
        logic [AW-1:0] rptr;
        logic [AW-1:0] rcnt;
        logic [1:0]    mode;
        logic          e1;
        logic          revert;
        logic          bit_o;
        logic          fsync;
    } rd_state_t;

    rd_state_t st_d, st_q;

    function automatic logic [AW-1:0] wrap_add(input logic [AW-1:0] a,
                                               input logic [CW-1:0] b,
                                               input logic [CW-1:0] d);
        logic [CW-1:0] s;
        s = {2'b00, a} + b;
        if (s >= d) s = s - d;
        return s[AW-1:0];
    endfunction

    function automatic logic [AW-1:0] wrap_sub(input logic [AW-1:0] a,
                                               input logic [CW-1:0] b,
                                               input logic [CW-1:0] d);
        logic [CW-1:0] ax, r;
        ax = {2'b00, a};
        r  = (ax >= b) ? (ax - b) : (ax + d - b);
        return r[AW-1:0];
    endfunction

    logic [CW-1:0] len_q, len_in, depth_q;
    logic [AW-1:0] sep, pos_eff;
    logic          cfg_chg, rev_set;
    logic [CW-1:0] pos_inc;

    assign len_q   = st_q.e1 ? E1_L : T1_L;
    assign len_in  = e1_sel ? E1_L : T1_L;
    assign depth_q = len_q + len_q;
    assign sep     = wrap_sub(wptr, {2'b00, st_q.rptr}, depth_q);
    assign cfg_chg = (mode != st_q.mode) || (e1_sel != st_q.e1);

    // Slip decision and read address; uses pointers only, never the read data.
    always_comb begin
        rd_addr = st_q.rptr;
        pos_eff = st_q.rcnt;
        rev_set = 1'b0;
        ev      = '0;
        if (cfg_chg) begin
            ev.unctrl = 1'b1;
        end else if (rd_en) begin
            if (st_q.mode == SB_BYPASS) begin
                rd_addr = wrap_sub(wptr, ONE, depth_q);
            end else if (st_q.mode == SB_SHORT && !st_q.revert) begin
                if (sep == '0) begin
                    rd_addr   = wrap_add(wptr, len_q, depth_q);
                    pos_eff   = '0;
                    ev.unctrl = 1'b1;
                end else if (st_q.rcnt == '0 && {2'b00, sep} > depth_q - GRD) begin
                    rd_addr = wrap_add(st_q.rptr, len_q, depth_q);
                    ev.ctrl = 1'b1;
                    rev_set = 1'b1;
                end
            end else if (st_q.rcnt == '0) begin
                if ({2'b00, sep} < GRD) begin
                    rd_addr = wrap_sub(st_q.rptr, len_q, depth_q);
                    ev.ctrl = 1'b1;
                    ev.dir  = 1'b1;
                end else if ({2'b00, sep} > depth_q - GRD) begin
                    rd_addr = wrap_add(st_q.rptr, len_q, depth_q);
                    ev.ctrl = 1'b1;
                end
            end
        end
    end

    // Next state from the decision above and the stored bit.
    always_comb begin
        st_d       = st_q;
        st_d.fsync = 1'b0;
        pos_inc    = {2'b00, pos_eff} + ONE;
        if (cfg_chg) begin
            st_d.mode   = mode;
            st_d.e1     = e1_sel;
            st_d.rptr   = len_in[AW-1:0];
            st_d.rcnt   = '0;
            st_d.revert = 1'b0;
        end else if (rd_en) begin
            st_d.bit_o = rd_data;
            st_d.rptr  = wrap_add(rd_addr, ONE, depth_q);
            st_d.fsync = (pos_eff == '0);
            st_d.rcnt  = (pos_inc >= len_q) ? '0 : pos_inc[AW-1:0];
            if (rev_set) st_d.revert = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.rptr <= T1_L[AW-1:0];
        end else begin
            st_q <= st_d;
        end
    end

    assign realign  = cfg_chg;
    assign depth    = depth_q[AW:0];
    assign rd_bit   = st_q.bit_o;
    assign rd_fsync = st_q.fsync;
    assign bypass   = (st_q.mode == SB_BYPASS);
    assign dly      = {2'b00, sep} > (st_q.e1 ? E1_L : CW'(T1_DLY_TH));

    assert_rptr_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ({2'b00, st_q.rptr} < depth_q));

    assert_sync_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev.ctrl |=> (st_q.rcnt == AW'(1)));

    assert_bypass_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == SB_BYPASS && !cfg_chg) |-> (!ev.ctrl && !ev.unctrl));
endmodule

// File: rtl/rxsb_flags.sv
module rxsb_flags import rxsb_pkg::*; #(
    parameter int HOLD_CYC = 64,
    localparam int HW = $clog2(HOLD_CYC + 1)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  sb_event_t ev,
    input  logic      hold_sel,
    input  logic      status_rd,
    input  logic      bypass,
    output logic      slip_ctrl,
    output logic      slip_unctrl,
    output logic      slip_dir,
    output logic      slip_any
);
    typedef struct packed {
        logic          c;
        logic          u;
        logic          dir;
        logic [HW-1:0] cnt;
    } flag_t;

    flag_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (ev.ctrl || ev.unctrl) begin
            if (status_rd && !hold_sel) begin
                fl_d.c = 1'b0;
                fl_d.u = 1'b0;
            end
            fl_d.c   = fl_d.c | ev.ctrl;
            fl_d.u   = fl_d.u | ev.unctrl;
            fl_d.dir = ev.dir;
            fl_d.cnt = HW'(HOLD_CYC);
        end else begin
            if (!hold_sel) begin
                if (status_rd) begin
                    fl_d.c = 1'b0;
                    fl_d.u = 1'b0;
                end
            end else if (fl_q.cnt == HW'(1)) begin
                fl_d.c = 1'b0;
                fl_d.u = 1'b0;
            end
            if (fl_q.cnt != '0) fl_d.cnt = fl_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign slip_ctrl   = fl_q.c & ~bypass;
    assign slip_unctrl = fl_q.u;
    assign slip_dir    = fl_q.dir;
    assign slip_any    = slip_ctrl | slip_unctrl;

    assert_event_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ev.ctrl |=> fl_q.c);

    assert_clear_on_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_sel && status_rd && !ev.ctrl && !ev.unctrl) |=> (!fl_q.c && !fl_q.u));

    assert_hold_keep_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_sel && fl_q.cnt > HW'(1) && fl_q.u) |=> fl_q.u);
endmodule

// File: rtl/rx_slip_buffer.sv
module rx_slip_buffer import rxsb_pkg::*; #(
    parameter int T1_LEN    = 193,
    parameter int E1_LEN    = 256,
    parameter int T1_DLY_TH = 192,
    parameter int GUARD     = 16,
    parameter int HOLD_CYC  = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic       e1_sel,
    input  logic       hold_sel,
    input  logic       wr_en,
    input  logic       wr_bit,
    input  logic       rd_en,
    output logic       rd_bit,
    output logic       rd_fsync,
    input  logic       status_rd,
    output logic       slip_ctrl,
    output logic       slip_unctrl,
    output logic       slip_dir,
    output logic       slip_any,
    output logic       dly_gt_frame
);
    localparam int DEPTH_MAX = 2 * E1_LEN;
    localparam int AW        = $clog2(DEPTH_MAX);

    logic [AW-1:0] wptr, rd_addr;
    logic [AW:0]   depth;
    logic          rd_data, realign, bypass;
    sb_event_t     ev;

    rxsb_store #(.DEPTH_MAX(DEPTH_MAX)) store_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bit(wr_bit),
        .realign(realign), .depth(depth), .rd_addr(rd_addr),
        .rd_data(rd_data), .wptr(wptr)
    );

    rxsb_reader #(
        .T1_LEN(T1_LEN), .E1_LEN(E1_LEN), .T1_DLY_TH(T1_DLY_TH),
        .GUARD(GUARD), .AW(AW)
    ) reader_i (
        .clk(clk), .rst_n(rst_n), .mode(mode_sel), .e1_sel(e1_sel),
        .rd_en(rd_en), .wptr(wptr), .rd_data(rd_data), .rd_addr(rd_addr),
        .realign(realign), .depth(depth), .rd_bit(rd_bit),
        .rd_fsync(rd_fsync), .dly(dly_gt_frame), .bypass(bypass), .ev(ev)
    );

    rxsb_flags #(.HOLD_CYC(HOLD_CYC)) flags_i (
        .clk(clk), .rst_n(rst_n), .ev(ev), .hold_sel(hold_sel),
        .status_rd(status_rd), .bypass(bypass), .slip_ctrl(slip_ctrl),
        .slip_unctrl(slip_unctrl), .slip_dir(slip_dir), .slip_any(slip_any)
    );

    assert_cfg_resync_R6: assert property (@(posedge clk) disable iff (!rst_n)
        realign |=> (slip_unctrl && !slip_dir && (wptr == '0)));
endmodule

// File: tb/rx_slip_buffer_tb_top.sv
module rx_slip_buffer_tb_top;
    localparam int HOLD = 64;
    localparam int G    = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       e1_sel = 1'b0, hold_sel = 1'b0, wr_en = 1'b0, wr_bit = 1'b0;
    logic       rd_en = 1'b0, status_rd = 1'b0;
    logic       rd_bit, rd_fsync, slip_ctrl, slip_unctrl, slip_dir, slip_any, dly_gt_frame;

    rx_slip_buffer #(.GUARD(G), .HOLD_CYC(HOLD)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .e1_sel(e1_sel),
        .hold_sel(hold_sel), .wr_en(wr_en), .wr_bit(wr_bit), .rd_en(rd_en),
        .rd_bit(rd_bit), .rd_fsync(rd_fsync), .status_rd(status_rd),
        .slip_ctrl(slip_ctrl), .slip_unctrl(slip_unctrl), .slip_dir(slip_dir),
        .slip_any(slip_any), .dly_gt_frame(dly_gt_frame)
    );

    int n_checks = 0, n_fail = 0;
    int mmem [0:511];
    int mw, mr, mcnt, mmode, me1, mrev, mbit, mfs, mc, mu, mdir, mhold;
    int n_rep = 0, n_del = 0, n_cfg = 0, n_ures = 0, n_rev = 0, n_byp = 0;
    int n_fs = 0, n_rd_clear = 0, n_hold_clear = 0;

    task automatic check(input int got, input int exp, input string tag);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 512; i++) mmem[i] = 0;
        mw = 0; mr = 193; mcnt = 0; mmode = 0; me1 = 0; mrev = 0;
        mbit = 0; mfs = 0; mc = 0; mu = 0; mdir = 0; mhold = 0;
    endtask

    task automatic model_step();
        int L, D, sep, a, pos;
        bit cfg, evc, evu;
        int edir;
        L = (me1 != 0) ? 256 : 193;
        D = 2 * L;
        sep = ((mw - mr) % D + D) % D;
        cfg = (int'(mode_sel) != mmode) || (int'(e1_sel) != me1);
        evc = 0; evu = 0; edir = 0;
        if (cfg) begin
            mmode = int'(mode_sel); me1 = int'(e1_sel);
            mr = (me1 != 0) ? 256 : 193;
            mcnt = 0; mrev = 0; mfs = 0; evu = 1; n_cfg++;
        end else if (rd_en) begin
            pos = mcnt; a = mr;
            if (mmode == 2) begin
                a = (mw - 1 + D) % D; n_byp++;
            end else if (mmode == 1 && mrev == 0) begin
                if (sep == 0) begin
                    a = (mw + L) % D; pos = 0; evu = 1; n_ures++;
                end else if (pos == 0 && sep > D - G) begin
                    a = (mr + L) % D; evc = 1; mrev = 1; n_rev++;
                end
            end else if (pos == 0) begin
                if (sep < G) begin
                    a = (mr - L + D) % D; evc = 1; edir = 1; n_rep++;
                end else if (sep > D - G) begin
                    a = (mr + L) % D; evc = 1; n_del++;
                end
            end
            mbit = mmem[a]; mr = (a + 1) % D;
            mfs = (pos == 0) ? 1 : 0;
            if (pos == 0) n_fs++;
            mcnt = (pos + 1) % L;
        end else begin
            mfs = 0;
        end
        if (cfg) mw = 0;
        else if (wr_en) begin
            mmem[mw] = int'(wr_bit); mw = (mw + 1) % D;
        end
        if (evc || evu) begin
            if (status_rd && !hold_sel) begin mc = 0; mu = 0; end
            if (evc) mc = 1;
            if (evu) mu = 1;
            mdir = edir; mhold = HOLD;
        end else begin
            if (!hold_sel) begin
                if (status_rd) begin
                    if (mc != 0 || mu != 0) n_rd_clear++;
                    mc = 0; mu = 0;
                end
            end else if (mhold == 1) begin
                if (mc != 0 || mu != 0) n_hold_clear++;
                mc = 0; mu = 0;
            end
            if (mhold != 0) mhold--;
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) model_reset();
        else        model_step();
    end

    task automatic compare();
        int D, sep, ec;
        D = (me1 != 0) ? 512 : 386;
        sep = ((mw - mr) % D + D) % D;
        ec = (mc != 0 && mmode != 2) ? 1 : 0;
        check(int'(rd_bit), mbit, "R1 rd_bit");
        check(int'(rd_fsync), mfs, "R2 rd_fsync");
        check(int'(slip_ctrl), ec, "R3 R4 R9 slip_ctrl");
        check(int'(slip_unctrl), mu, "R6 R7 slip_unctrl");
        check(int'(slip_dir), mdir, "R3 R4 slip_dir");
        check(int'(slip_any), (ec != 0 || mu != 0) ? 1 : 0, "R10 slip_any");
        check(int'(dly_gt_frame), (sep > ((me1 != 0) ? 256 : 192)) ? 1 : 0, "R5 dly_gt_frame");
    endtask

    task automatic run_phase(input int cycles, input int wr_pct, input int rd_pct, input int sr_pct);
        int acc_w, acc_r;
        acc_w = 0; acc_r = 0;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            compare();
            acc_w += wr_pct; acc_r += rd_pct;
            wr_en = (acc_w >= 100);
            if (acc_w >= 100) acc_w -= 100;
            rd_en = (acc_r >= 100);
            if (acc_r >= 100) acc_r -= 100;
            wr_bit = $urandom_range(1);
            status_rd = ($urandom_range(99) < sr_pct);
        end
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; status_rd = 1'b0;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL R1 watchdog actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R13 reset state
        check(int'(slip_ctrl), 0, "R13 reset slip_ctrl");
        check(int'(slip_unctrl), 0, "R13 reset slip_unctrl");
        check(int'(slip_any), 0, "R13 reset slip_any");
        check(int'(rd_bit), 0, "R13 reset rd_bit");
        check(int'(rd_fsync), 0, "R13 reset rd_fsync");
        check(int'(dly_gt_frame), 1, "R13 reset dly_gt_frame");
        rst_n = 1'b1;
        run_phase(2000, 50, 50, 1);     // steady T1
        run_phase(10000, 53, 50, 1);    // R4 deletes, R11 reads
        run_phase(10000, 50, 53, 1);    // R3 repeats
        hold_sel = 1'b1;
        run_phase(8000, 53, 50, 5);     // R12 hold, reads ignored
        hold_sel = 1'b0; e1_sel = 1'b1;
        run_phase(10000, 53, 50, 2);    // R6 framing change, E1 deletes
        mode_sel = 2'b01;
        run_phase(10000, 50, 53, 0);    // R7 short underrun
        run_phase(10000, 53, 50, 1);    // R8 short revert
        mode_sel = 2'b10;
        run_phase(2000, 60, 60, 1);     // R9 bypass
        mode_sel = 2'b00; e1_sel = 1'b0;
        run_phase(2000, 50, 50, 1);
        check(n_rep > 0, 1, "R3 repeat slip reached");
        check(n_del > 0, 1, "R4 delete slip reached");
        check(n_cfg > 0, 1, "R6 config realign reached");
        check(n_ures > 0, 1, "R7 short underrun reached");
        check(n_rev > 0, 1, "R8 short revert reached");
        check(n_byp > 0, 1, "R9 bypass reads reached");
        check(n_fs > 0, 1, "R2 frame syncs reached");
        check(n_rd_clear > 0, 1, "R11 clear on read reached");
        check(n_hold_clear > 0, 1, "R12 hold expiry reached");
        summary();
        $finish;
    end
endmodule